// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block collects the interrupt sources of a serial port into one sticky raw status vector of eleven bits, applies a software mask to it and drives a single active-high interrupt request. Event pulses from the surrounding receiver, transmitter, error detectors and modem-line logic set raw bits. Software works through a 32-bit, word-addressed register bus. It writes the mask, reads the raw and the masked views, and clears bits through a write-only clear word.

The block also handles the transmit data word. Each write to it presents the low byte on a transmit strobe interface and raises the transmit source. A DMA control word is kept as a plain storage location. The request line is registered. Any change to the raw status or to the mask shows on the line one clock later.

Top module: `uart_isr_unit`

## Requirements
- R1: After reset the raw status, the mask, the DMA control word and the request output `irq` are all zero.
- R2: A 1 on bit i of `evt_src` sets raw bit i at the next clock edge. The bit stays set until it is cleared. Raw status reads at word 15. The layout is: bits 3..0 modem sources, bit 4 receive, bit 5 transmit, bit 6 receive timeout, bits 10..7 error sources.
- R3: Word 14 is the read/write mask. Bits 10..0 are stored, and bits 31..11 read as zero.
- R4: Word 16 reads the raw status ANDed with the mask.
- R5: Writing word 17 clears each raw bit whose position holds a 1 in the written data. Word 17 reads as zero.
- R6: If an event and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R7: A write to word 0 drives `tx_strobe` high in that cycle with `tx_byte` equal to the low 8 bits of the data. It also sets raw bit 5 at the next edge.
- R8: `irq` equals the OR of (raw AND mask) as it stood one clock earlier. A mask write or a clear therefore changes `irq` one cycle after the register updates.
- R9: Word 18 stores and returns a 32-bit DMA control value. Setting its low two bits changes neither the raw status nor `irq`.
- R10: Raw status bits 31..11 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle `bus_rd_en` is high, zero otherwise |
| evt_src | input | 11 | Per-source event pulses, same layout as the raw status |
| tx_byte | output | 8 | Transmit byte from a write to word 0 |
| tx_strobe | output | 1 | High in the cycle word 0 is written |
| irq | output | 1 | Registered interrupt request |

## Verification
Events are applied both to sources that are masked and to sources that are enabled. Comparing the raw view with the masked view shows whether the AND is applied, and the request line shows whether masked sources are kept off it. The request is sampled one and two cycles after an event, a clear and a mask write, which separates the registered behaviour from a combinational one. A clear and an event aimed at the same bit in one cycle shows which of the two has priority. A write to the DMA word with its low bits set, followed by a read of the raw status and of `irq`, shows that the write has no side effect.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;
    localparam int SRC_N  = 11;
    localparam int TX_BIT = 5;
    localparam int W_DATA   = 0;
    localparam int W_MASK   = 14;
    localparam int W_RAW    = 15;
    localparam int W_MASKED = 16;
    localparam int W_CLEAR  = 17;
    localparam int W_DMA    = 18;
    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/isr_status.sv
module isr_status
    import uart_isr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  logic     clr_en_i,
    input  src_vec_t clr_mask_i,
    input  logic     mask_we_i,
    input  src_vec_t mask_d_i,
    output src_vec_t raw_o,
    output src_vec_t mask_o
);
    src_vec_t raw_q;
    src_vec_t mask_q;

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                raw_q[i] <= 1'b0;
            else if (set_i[i])
                raw_q[i] <= 1'b1;
            else if (clr_en_i && clr_mask_i[i])
                raw_q[i] <= 1'b0;
        end

        AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> raw_q[i]); // R6
        AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_mask_i[i] && !set_i[i]) |=> !raw_q[i]); // R5
        AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !(clr_en_i && clr_mask_i[i])) |=> $stable(raw_q[i])); // R2
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we_i)
            mask_q <= mask_d_i;
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_q == $past(mask_d_i))); // R3

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/isr_reqgen.sv
module isr_reqgen
    import uart_isr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t raw_i,
    input  src_vec_t mask_i,
    output logic     irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(raw_i & mask_i);
    end

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_q == (|($past(raw_i) & $past(mask_i))))); // R8

    assign irq_o = irq_q;
endmodule

// File: rtl/isr_bus.sv
module isr_bus
    import uart_isr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  src_vec_t          raw_i,
    input  src_vec_t          mask_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              tx_wr_o,
    output logic [7:0]        tx_byte_o,
    output logic              clr_en_o,
    output logic              mask_we_o
);
    localparam int PAD_W = DATA_W - SRC_N;

    logic [DATA_W-1:0] dma_q;

    always_comb begin
        tx_wr_o   = wr_en_i && (addr_i == ADDR_W'(W_DATA));
        clr_en_o  = wr_en_i && (addr_i == ADDR_W'(W_CLEAR));
        mask_we_o = wr_en_i && (addr_i == ADDR_W'(W_MASK));
        tx_byte_o = wdata_i[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dma_q <= '0;
        else if (wr_en_i && (addr_i == ADDR_W'(W_DMA)))
            dma_q <= wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                ADDR_W'(W_MASK):   rdata_o = {{PAD_W{1'b0}}, mask_i};
                ADDR_W'(W_RAW):    rdata_o = {{PAD_W{1'b0}}, raw_i};
                ADDR_W'(W_MASKED): rdata_o = {{PAD_W{1'b0}}, raw_i & mask_i};
                ADDR_W'(W_DMA):    rdata_o = dma_q;
                default:           rdata_o = '0;
            endcase
        end
    end

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(W_CLEAR)) |-> (rdata_o == '0)); // R5
endmodule

// File: rtl/uart_isr_unit.sv
module uart_isr_unit
    import uart_isr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  evt_src,
    output logic [7:0]        tx_byte,
    output logic              tx_strobe,
    output logic              irq
);
    src_vec_t raw;
    src_vec_t mask;
    src_vec_t set_vec;
    logic     tx_wr;
    logic     clr_en;
    logic     mask_we;

    always_comb begin
        set_vec = evt_src;
        set_vec[TX_BIT] = evt_src[TX_BIT] | tx_wr;
    end

    isr_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bus_wr_en),
        .rd_en_i   (bus_rd_en),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .raw_i     (raw),
        .mask_i    (mask),
        .rdata_o   (bus_rdata),
        .tx_wr_o   (tx_wr),
        .tx_byte_o (tx_byte),
        .clr_en_o  (clr_en),
        .mask_we_o (mask_we)
    );

    isr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_en_i   (clr_en),
        .clr_mask_i (bus_wdata[SRC_N-1:0]),
        .mask_we_i  (mask_we),
        .mask_d_i   (bus_wdata[SRC_N-1:0]),
        .raw_o      (raw),
        .mask_o     (mask)
    );

    isr_reqgen u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .mask_i(mask),
        .irq_o (irq)
    );

    assign tx_strobe = tx_wr;

    AST_TX_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(W_DATA)) |=> raw[TX_BIT]); // R7
endmodule

// File: tb/uart_isr_unit_tb.sv
module uart_isr_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic              bus_rd_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [10:0]       evt_src = '0;
    logic [7:0]        tx_byte;
    logic              tx_strobe;
    logic              irq;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    uart_isr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_src   (evt_src),
        .tx_byte   (tx_byte),
        .tx_strobe (tx_strobe),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc(input logic wr, input logic rd, input int a,
                       input logic [31:0] d, input logic [10:0] e);
        @(negedge clk);
        bus_wr_en = wr;
        bus_rd_en = rd;
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        evt_src   = e;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 0, 32'h0, 11'h0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 11'h0);
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0, 11'h0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data one step after the edge that ends the read cycle
    always @(posedge clk) begin
        #1;
        if (bus_rd_en) begin
            if (exp_q.size() == 0) begin
                chk("read without expectation", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq during reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(15, 32'h0, "R1 raw after reset");
        rd(14, 32'h0, "R1 mask after reset");
        rd(18, 32'h0, "R1 dma after reset");
        idle();
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        wr(14, 32'hFFFF_FFFF);
        rd(14, 32'h0000_07FF, "R3 mask upper bits zero");
        wr(14, 32'h0000_0010);
        rd(14, 32'h0000_0010, "R3 mask readback");

        cyc(1'b0, 1'b0, 0, 32'h0, 11'h001);
        rd(15, 32'h0000_0001, "R2 modem bit0 sticky");
        rd(16, 32'h0000_0000, "R4 masked hides modem");
        idle();
        chk("R8 masked source keeps irq low", {31'h0, irq}, 32'h0);

        cyc(1'b0, 1'b0, 0, 32'h0, 11'h010);
        idle();
        chk("R8 irq one cycle lag", {31'h0, irq}, 32'h0);
        idle();
        chk("R8 irq rises", {31'h0, irq}, 32'h1);
        rd(15, 32'h0000_0011, "R2 receive bit set");
        rd(16, 32'h0000_0010, "R4 masked receive");

        wr(17, 32'h0000_0010);
        rd(15, 32'h0000_0001, "R5 clear receive bit");
        idle();
        chk("R5 irq low after clear", {31'h0, irq}, 32'h0);
        rd(17, 32'h0, "R5 clear word reads zero");

        cyc(1'b1, 1'b0, 17, 32'h0000_0080, 11'h080);
        rd(15, 32'h0000_0081, "R6 set wins over clear");

        wr(17, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b0, 0, 32'h0, 11'h7FF);
        rd(15, 32'h0000_07FF, "R10 upper raw bits zero");
        wr(17, 32'hFFFF_FFFF);
        rd(15, 32'h0, "R5 clear all");

        wr(14, 32'h0000_0020);
        wr(0, 32'h0000_01A5);
        #1;
        chk("R7 tx strobe", {31'h0, tx_strobe}, 32'h1);
        chk("R7 tx byte", {24'h0, tx_byte}, 32'h0000_00A5);
        rd(15, 32'h0000_0020, "R7 transmit raw bit");
        #1;
        chk("R7 no strobe on read", {31'h0, tx_strobe}, 32'h0);
        rd(16, 32'h0000_0020, "R4 masked transmit");
        idle();
        chk("R8 irq from transmit", {31'h0, irq}, 32'h1);

        wr(14, 32'h0);
        idle();
        chk("R8 mask write lag", {31'h0, irq}, 32'h1);
        idle();
        chk("R8 mask write drops irq", {31'h0, irq}, 32'h0);

        wr(18, 32'h0000_0003);
        rd(18, 32'h0000_0003, "R9 dma readback");
        rd(15, 32'h0000_0020, "R9 dma no raw effect");
        idle();
        chk("R9 dma no irq", {31'h0, irq}, 32'h0);

        idle();
        idle();
        chk("scoreboard drained", exp_q.size(), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule